// File: doc/BRIEF.md
# Parallel-to-Serial Configuration Byte Loader

This block takes bytes from a host processor over an asynchronous 8-bit port and sends them out one bit at a time on a serial data pin. A serial clock is produced inside the block, and each bit has one clock period. The host port has two chip selects of opposite polarity, a write strobe, a read strobe, an input data bus, a status output bus with its enable, and a ready pin. All host inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and a write takes effect when its strobe ends.

Storage has two levels. A holding register accepts the next byte while the shift register is still sending the current one. Ready is low while the holding register is occupied. The host can poll the ready pin, or it can read ready back as bit 7 of a status read. Bytes follow one another on the serial pin with no gap. A write that arrives while both levels are full is dropped and sets a sticky overrun flag.

Top module: `periph_byte_serializer`

## Requirements
- R1: A write is recognised only while `host_cs0_n`=0, `host_cs1`=1, `host_rs_n`=1 and `host_ws_n`=0. Any other combination leaves the buffers, the ready pin and the serial output unchanged.
- R2: The byte is the value on `host_din` during the write. It is taken when the write condition ends. Later changes on `host_din` have no effect.
- R3: Each byte is sent least significant bit first on `ser_data`. Every bit lasts one serial period of `SCK_DIV` system clocks. `ser_clk` is low in the first half of the period and high in the second half, so it has exactly one rising edge per bit.
- R4: While the shift register holds no unsent bits, `ser_clk` stays low and no edges appear.
- R5: A byte written while another byte is shifting is accepted into the holding register. `ready` is low from the moment a byte is captured until the holding register has passed its byte to the shift register.
- R6: When the holding register is full as the last bit of a byte ends, bit 0 of the next byte follows bit 7 directly. The serial period stays at `SCK_DIV` clocks with no gap.
- R7: A status read (`host_rs_n`=0, `host_cs0_n`=0, `host_cs1`=1) sets `host_dout_oe`=1 and drives `host_dout` = {ready, 7'b0}. Outside a status read, `host_dout_oe`=0.
- R8: A write that arrives while the holding register is full is dropped and sets `overrun`. `overrun` stays at 1 until reset.
- R9: After reset, `ready`=1, `ser_clk`=0, `overrun`=0 and `host_dout_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs0_n | input | 1 | Active-low chip select (async) |
| host_cs1 | input | 1 | Active-high chip select (async) |
| host_ws_n | input | 1 | Active-low write strobe (async) |
| host_rs_n | input | 1 | Active-low read strobe (async) |
| host_din | input | 8 | Host write data (async) |
| host_dout | output | 8 | Status byte, ready on bit 7 |
| host_dout_oe | output | 1 | High during a decoded status read |
| ready | output | 1 | High when the holding register is empty |
| overrun | output | 1 | Sticky: a write was dropped |
| ser_clk | output | 1 | Serial clock, rising edge mid-bit |
| ser_data | output | 1 | Serial data, LSB first |

## Verification
The bench first sends a single byte into an empty block. This checks bit order and serial period without any buffering. Next it sends three bytes, each written as soon as ready returns. Here the timing of ready and the seamless hand-over between bytes become visible, since any idle period would show as a stretched gap between serial clock edges. A burst of three writes with no wait overfills both levels, so a dropped byte can be told apart from a delayed one. Writes with a chip select at the wrong level, and status reads in the idle and full states, show that decoding is exact and that bit 7 follows buffer occupancy.

// File: rtl/periph_byte_serializer.sv
module periph_byte_serializer #(
  parameter int SCK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_cs0_n,
  input  logic       host_cs1,
  input  logic       host_ws_n,
  input  logic       host_rs_n,
  input  logic [7:0] host_din,
  output logic [7:0] host_dout,
  output logic       host_dout_oe,
  output logic       ready,
  output logic       overrun,
  output logic       ser_clk,
  output logic       ser_data
);
  localparam int CW = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam logic [CW-1:0] CMAX  = CW'(SCK_DIV - 1);
  localparam logic [CW-1:0] CHALF = CW'(SCK_DIV / 2);

  logic [3:0] ctl_a, ctl_b;
  logic [7:0] din_a, din_b, wr_data;
  logic       wr_q;
  logic       hold_v, sh_v;
  logic [7:0] hold_d, sh_d;
  logic [2:0] bitn;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a <= 4'b1011;
      ctl_b <= 4'b1011;
      din_a <= '0;
      din_b <= '0;
    end else begin
      ctl_a <= {host_cs0_n, host_cs1, host_ws_n, host_rs_n};
      ctl_b <= ctl_a;
      din_a <= host_din;
      din_b <= din_a;
    end
  end

  wire wr_b  = ~ctl_b[3] & ctl_b[2] & ~ctl_b[1] & ctl_b[0];
  wire rd_b  = ~ctl_b[3] & ctl_b[2] & ~ctl_b[0];
  wire wr_end = wr_q & ~wr_b;
  wire take  = wr_end & ~hold_v;
  wire tick  = sh_v && (cnt == CMAX);
  wire last  = tick && (bitn == 3'd7);
  wire load  = hold_v && (!sh_v || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wr_data <= '0;
      overrun <= 1'b0;
    end else begin
      wr_q <= wr_b;
      if (wr_b) wr_data <= din_b;
      if (wr_end && hold_v) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
    end else if (take) begin
      hold_v <= 1'b1;
      hold_d <= wr_data;
    end else if (load) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_v <= 1'b0;
      sh_d <= '0;
      bitn <= '0;
      cnt  <= '0;
    end else begin
      cnt <= (sh_v && cnt != CMAX) ? cnt + 1'b1 : '0;
      if (load) begin
        sh_v <= 1'b1;
        sh_d <= hold_d;
        bitn <= '0;
      end else if (last) begin
        sh_v <= 1'b0;
      end else if (tick) begin
        sh_d <= sh_d >> 1;
        bitn <= bitn + 1'b1;
      end
    end
  end

  assign ready        = ~hold_v;
  assign ser_clk      = sh_v && (cnt >= CHALF);
  assign ser_data     = sh_v & sh_d[0];
  assign host_dout_oe = rd_b;
  assign host_dout    = rd_b ? {ready, 7'b0} : 8'h00;

  // R4
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_v |-> !ser_clk);
  // R5
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !sh_v) |=> (sh_v && !hold_v));
  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_v && $past(sh_v) && !$past(tick) && !$past(load)) |-> $stable(sh_d));
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(hold_v));
  // R7
  status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_dout_oe |-> (host_dout[6:0] == 7'd0 && host_dout[7] == ready));
endmodule

// File: tb/periph_byte_serializer_tb.sv
`timescale 1ns/1ps
module periph_byte_serializer_tb;
  localparam int DIV = 4;
  localparam real TCK = 5.0;

  logic clk = 0, rst_n = 0;
  logic cs0_n = 1, cs1 = 1, ws_n = 1, rs_n = 1;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic oe, rdy, ovr, sclk, sdat;
  int total = 0, bad = 0;
  logic bits[$];
  real  stamps[$];

  periph_byte_serializer #(.SCK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_cs0_n(cs0_n), .host_cs1(cs1),
    .host_ws_n(ws_n), .host_rs_n(rs_n), .host_din(din), .host_dout(dout),
    .host_dout_oe(oe), .ready(rdy), .overrun(ovr), .ser_clk(sclk), .ser_data(sdat));

  always #2.5 clk = ~clk;

  always @(posedge sclk) begin
    bits.push_back(sdat);
    stamps.push_back($realtime);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    bits.delete(); stamps.delete();
  endtask

  task automatic host_write(input logic [7:0] d, input logic c1);
    @(negedge clk);
    cs0_n = 0; cs1 = c1; rs_n = 1; din = d; ws_n = 0;
    repeat (3) @(negedge clk);
    ws_n = 1; din = ~d;
    @(negedge clk);
    cs0_n = 1; cs1 = 1; din = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_bits(input int n);
    for (int i = 0; i < 3000 && bits.size() < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input int limit, output int waited);
    waited = 0;
    while (!rdy && waited < limit) begin @(negedge clk); waited++; end
  endtask

  task automatic check_bytes(input string req, input logic [7:0] exp[]);
    for (int b = 0; b < exp.size(); b++) begin
      logic [7:0] got = 8'h00;
      for (int k = 0; k < 8; k++)
        if (b*8+k < bits.size()) got[k] = bits[b*8+k];
      chk(req, got, exp[b]);
    end
  endtask

  task automatic check_gaps(input string req);
    int badgap = 0;
    for (int i = 1; i < stamps.size(); i++) begin
      real g = stamps[i] - stamps[i-1];
      if (g < DIV*TCK - 0.1 || g > DIV*TCK + 0.1) badgap++;
    end
    chk(req, badgap, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 ready", rdy, 1);
    chk("R9 ser_clk", sclk, 0);
    chk("R9 overrun", ovr, 0);
    chk("R9 oe", oe, 0);
  endtask

  task automatic t_single();
    do_reset();
    host_write(8'hA5, 1'b1);
    wait_bits(8);
    check_bytes("R3/R2 single byte LSB first", '{8'hA5});
    check_gaps("R3 serial period");
    repeat (40) @(negedge clk);
    chk("R4 no extra edges", bits.size(), 8);
    chk("R4 ser_clk idle low", sclk, 0);
  endtask

  task automatic t_ignored();
    do_reset();
    host_write(8'h7E, 1'b0);
    @(negedge clk);
    cs0_n = 1; cs1 = 1; rs_n = 1; ws_n = 0; din = 8'h81;
    repeat (4) @(negedge clk);
    ws_n = 1;
    repeat (60) @(negedge clk);
    chk("R1 bad select sends nothing", bits.size(), 0);
    chk("R1 ready untouched", rdy, 1);
  endtask

  task automatic t_stream();
    int w;
    do_reset();
    host_write(8'h3C, 1'b1);
    wait_ready(50, w);
    host_write(8'hC3, 1'b1);
    repeat (2) @(negedge clk);
    chk("R5 busy with second byte held", rdy, 0);
    wait_ready(8*DIV + 20, w);
    chk("R5 ready returns", rdy, 1);
    host_write(8'h5A, 1'b1);
    wait_bits(24);
    check_bytes("R6 stream", '{8'h3C, 8'hC3, 8'h5A});
    check_gaps("R6 no gap across bytes");
  endtask

  task automatic t_status();
    do_reset();
    @(negedge clk); cs0_n = 0; cs1 = 1; rs_n = 0;
    repeat (4) @(negedge clk);
    chk("R7 oe on read", oe, 1);
    chk("R7 idle status", dout, 8'h80);
    cs1 = 0;
    repeat (4) @(negedge clk);
    chk("R7 no drive with cs1 low", oe, 0);
    cs0_n = 1; cs1 = 1; rs_n = 1;
    repeat (4) @(negedge clk);
    chk("R7 no drive after read", oe, 0);
  endtask

  task automatic t_overrun();
    do_reset();
    host_write(8'h11, 1'b1);
    host_write(8'h22, 1'b1);
    @(negedge clk); cs0_n = 0; cs1 = 1; rs_n = 0;
    repeat (4) @(negedge clk);
    chk("R7 busy status", dout, 8'h00);
    cs0_n = 1; rs_n = 1;
    repeat (2) @(negedge clk);
    chk("R8 no overrun yet", ovr, 0);
    host_write(8'h33, 1'b1);
    chk("R8 overrun set", ovr, 1);
    wait_bits(16);
    repeat (80) @(negedge clk);
    chk("R8 dropped byte not sent", bits.size(), 16);
    check_bytes("R8 kept bytes", '{8'h11, 8'h22});
    chk("R8 overrun sticky", ovr, 1);
    do_reset();
    chk("R8 reset clears overrun", ovr, 0);
  endtask

  initial begin
    #(200000 * TCK);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_ignored();
    t_stream();
    t_status();
    t_overrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule